// File: doc/BRIEF.md
# Protected Register Write Guard

This block keeps one critical 8-bit control register, for example a power-save control register, safe from stray stores issued by a program that has lost control. It sits on a simple single-cycle register bus made of an address, a write strobe, byte write data, per-bit write enables and combinational read data. A protected write must be a two-store pair. First comes a store of any value to the command register. Then the very next bus write goes to the protected register. Any other ordering is refused, and a sticky protection-error flag is raised in the status register.

The command store arms a one-shot unlock. The block drives a hold output to the interrupt controller from the cycle of the command store until the following bus write completes. This keeps an interrupt from slipping between the two stores. The unlock is used up by exactly one following write, whether that write was accepted or refused. Idle bus cycles between the two stores do not use it up.

Top module: `prw_guard`

## Requirements
- R1: After reset the protected register holds 00H, the status register reads 00H and irq_hold is low.
- R2: A write to CMD_ADDR (byte 0xFFFFF1FC), whatever its data, arms an unlock. If the next bus write goes to PROT_ADDR (default 0xFFFFF1F0), its full data byte is stored into the protected register, and bus_be has no effect on that write.
- R3: A write to PROT_ADDR with no pending unlock leaves the protected register unchanged and sets the error flag.
- R4: When the write that follows a command write goes to any address other than PROT_ADDR, the error flag is set, the protected register is unchanged and the unlock is consumed.
- R5: An unlock is cleared by exactly one following bus write. A second write to PROT_ADDR after an accepted one is refused with an error.
- R6: irq_hold is high in the cycle of a command write and in every later cycle until the edge that completes the next bus write, including idle cycles in between. It is low at all other times.
- R7: The status register at STS_ADDR (byte 0xFFFFF802) reads {7'b0, err}, with bit 0 as the error flag (1 = a protection error occurred). The flag is sticky. A write with bus_be[0]=1 and bus_wdata[0]=0 clears it. Writing 1, or writing with bus_be[0]=0, leaves it unchanged.
- R8: If the write that breaks a sequence is itself a status write that clears bit 0, the error flag ends at 1: setting takes priority over clearing.
- R9: A command write while an unlock is already pending sets the error flag and leaves a fresh unlock armed.
- R10: Reading PROT_ADDR returns the protected register at any time. Reading an address other than PROT_ADDR, STS_ADDR or CMD_ADDR returns 00H. The value read at CMD_ADDR is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address for both read and write |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W | Per-bit write enables, used by the status register |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| prot_q | output | DATA_W | Current protected register value |
| err_flag | output | 1 | Sticky protection-error flag |
| irq_hold | output | 1 | Holds interrupt acknowledgement across the unlock pair |

## Verification
The error-flag logic can see a set and a software clear in the same cycle. This happens when the write right after a command store is a status write that clears bit 0. The bench provokes this on purpose and expects the flag to read 1 afterwards. A long pseudo-random run of commands, protected writes, status writes and idle cycles also hits the collision many times. A bench-side reference computed from the requirements judges every one of those cycles.

// File: rtl/prw_pkg.sv
package prw_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STS  = 2'd2,
    SEL_PROT = 2'd3
  } prw_sel_e;
endpackage

// File: rtl/prw_decode.sv
module prw_decode
  import prw_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 32'hFFFF_F1FC,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 32'hFFFF_F802,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 32'hFFFF_F1F0
) (
  input  logic [ADDR_W-1:0] addr,
  output prw_sel_e          sel
);
  always_comb begin
    if (addr == CMD_ADDR)       sel = SEL_CMD;
    else if (addr == STS_ADDR)  sel = SEL_STS;
    else if (addr == PROT_ADDR) sel = SEL_PROT;
    else                        sel = SEL_NONE;
  end
endmodule

// File: rtl/prw_seq.sv
module prw_seq
  import prw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  prw_sel_e sel,
  output logic     armed_q,
  output logic     irq_hold,
  output logic     err_set,
  output logic     prot_wr_ok
);
  logic cmd_wr;

  assign cmd_wr     = wr_en && (sel == SEL_CMD);
  assign prot_wr_ok = wr_en && (sel == SEL_PROT) && armed_q;
  // refused: protected write while idle, or any other write while armed
  assign err_set    = wr_en && ((sel == SEL_PROT) ? !armed_q : armed_q);
  assign irq_hold   = armed_q || cmd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= cmd_wr;
  end
endmodule

// File: rtl/prw_regs.sv
module prw_regs
  import prw_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       ERR_BIT  = 0,
  parameter logic [DATA_W-1:0] PROT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  prw_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] be,
  input  logic              prot_wr_ok,
  input  logic              err_set,
  output logic [DATA_W-1:0] prot_q,
  output logic [DATA_W-1:0] sts_q,
  output logic [DATA_W-1:0] rdata
);
  logic sts_wr;
  assign sts_wr = wr_en && (sel == SEL_STS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prot_q <= PROT_RST;
    else if (prot_wr_ok) prot_q <= wdata;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_sts
    if (i == ERR_BIT) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             flag_q <= 1'b0;
        else if (err_set)                       flag_q <= 1'b1;
        else if (sts_wr && be[i] && !wdata[i])  flag_q <= 1'b0;
      end
      assign sts_q[i] = flag_q;
    end else begin : g_rsvd
      assign sts_q[i] = 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_STS:  rdata = sts_q;
      SEL_PROT: rdata = prot_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/prw_guard.sv
module prw_guard
  import prw_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       ERR_BIT   = 0,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 32'hFFFF_F1FC,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 32'hFFFF_F802,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 32'hFFFF_F1F0,
  parameter logic [DATA_W-1:0] PROT_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] prot_q,
  output logic              err_flag,
  output logic              irq_hold
);
  prw_sel_e          sel;
  logic              armed;
  logic              err_set;
  logic              prot_wr_ok;
  logic [DATA_W-1:0] sts_q;

  prw_decode #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .STS_ADDR(STS_ADDR), .PROT_ADDR(PROT_ADDR)
  ) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  prw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .sel(sel),
    .armed_q(armed), .irq_hold(irq_hold), .err_set(err_set), .prot_wr_ok(prot_wr_ok)
  );

  prw_regs #(
    .DATA_W(DATA_W), .ERR_BIT(ERR_BIT), .PROT_RST(PROT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .sel(sel),
    .wdata(bus_wdata), .be(bus_be), .prot_wr_ok(prot_wr_ok), .err_set(err_set),
    .prot_q(prot_q), .sts_q(sts_q), .rdata(bus_rdata)
  );

  assign err_flag = sts_q[ERR_BIT];
endmodule

// File: rtl/prw_guard_chk.sv
module prw_guard_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       ERR_BIT   = 0,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 32'hFFFF_F1FC,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 32'hFFFF_F802,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 32'hFFFF_F1F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_be,
  input logic              armed,
  input logic              irq_hold,
  input logic [DATA_W-1:0] prot_q,
  input logic              err_flag
);
  logic hit_prot, hit_cmd, hit_sts;
  assign hit_prot = bus_addr == PROT_ADDR;
  assign hit_cmd  = bus_addr == CMD_ADDR;
  assign hit_sts  = bus_addr == STS_ADDR;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_prot && armed) |=> (prot_q == $past(bus_wdata)));

  p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_prot && !armed) |=> (err_flag && $stable(prot_q)));

  p_other_keeps_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && hit_prot) |=> $stable(prot_q));

  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit_cmd) |=> !armed);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_hold);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(bus_we && hit_sts && bus_be[ERR_BIT] && !bus_wdata[ERR_BIT])) |=> err_flag);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_we && !hit_prot) |=> err_flag);

  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_cmd) |=> armed);
endmodule

bind prw_guard prw_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_BIT(ERR_BIT),
  .CMD_ADDR(CMD_ADDR), .STS_ADDR(STS_ADDR), .PROT_ADDR(PROT_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_be(bus_be), .armed(armed), .irq_hold(irq_hold),
  .prot_q(prot_q), .err_flag(err_flag)
);

// File: tb/prw_guard_tb_top.sv
module prw_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_CMD  = 32'hFFFF_F1FC;
  localparam logic [31:0] A_STS  = 32'hFFFF_F802;
  localparam logic [31:0] A_PROT = 32'hFFFF_F1F0;
  localparam logic [31:0] A_OTH  = 32'hFFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = A_OTH;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_be = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  prot_q;
  logic        err_flag;
  logic        irq_hold;

  int checks = 0;
  int fails = 0;

  // reference state, derived from the requirements
  logic       m_armed = 1'b0;
  logic       m_err = 1'b0;
  logic [7:0] m_prot = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  prw_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .prot_q(prot_q), .err_flag(err_flag), .irq_hold(irq_hold)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle; inputs change at the falling edge
  task automatic cyc(input string tag, input logic we, input logic [31:0] a,
                     input logic [7:0] d, input logic [7:0] be);
    logic nerr;
    bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    #1;
    chk({tag, " R6 hold"}, {7'b0, irq_hold}, {7'b0, m_armed || (we && a == A_CMD)});
    @(negedge clk);
    if (we) begin
      nerr = m_err;
      if (a == A_STS && be[0] && !d[0]) nerr = 1'b0;
      if (a == A_PROT) begin
        if (m_armed) m_prot = d; else nerr = 1'b1;
      end else if (m_armed) nerr = 1'b1;
      m_err   = nerr;
      m_armed = (a == A_CMD);
    end
    bus_we = 1'b0;
    chk({tag, " prot"}, prot_q, m_prot);
    chk({tag, " err"}, {7'b0, err_flag}, {7'b0, m_err});
  endtask

  task automatic rd(input string tag, input logic [31:0] a, input logic [7:0] exp);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 prot", prot_q, 8'h00);
    chk("R1 hold", {7'b0, irq_hold}, 8'h00);
    rd("R1 status", A_STS, 8'h00);

    // R2 unlock with dummy data, then write; bus_be ignored for prot
    cyc("R2 cmd", 1, A_CMD, 8'h00, 8'h00);
    cyc("R2 prot", 1, A_PROT, 8'hA5, 8'h00);
    chk("R2 value", prot_q, 8'hA5);
    chk("R2 no err", {7'b0, err_flag}, 8'h00);
    // R10 reads
    rd("R10 prot read", A_PROT, 8'hA5);
    rd("R10 unmapped", A_OTH, 8'h00);
    // R5 second write refused
    cyc("R5 second", 1, A_PROT, 8'h3C, 8'hFF);
    chk("R5 unchanged", prot_q, 8'hA5);
    chk("R5 err", {7'b0, err_flag}, 8'h01);
    rd("R7 status read", A_STS, 8'h01);
    // R7 write 1 and masked write have no effect; write 0 clears
    cyc("R7 write1", 1, A_STS, 8'hFF, 8'hFF);
    chk("R7 write1 keeps", {7'b0, err_flag}, 8'h01);
    cyc("R7 masked", 1, A_STS, 8'h00, 8'hFE);
    chk("R7 masked keeps", {7'b0, err_flag}, 8'h01);
    cyc("R7 clear", 1, A_STS, 8'h00, 8'h01);
    rd("R7 cleared", A_STS, 8'h00);
    // R3 unarmed write
    cyc("R3 unarmed", 1, A_PROT, 8'h11, 8'hFF);
    chk("R3 unchanged", prot_q, 8'hA5);
    chk("R3 err", {7'b0, err_flag}, 8'h01);
    cyc("R3 clr", 1, A_STS, 8'h00, 8'hFF);
    // R6 idle cycles keep hold; R4 other address consumes unlock
    cyc("R6 cmd", 1, A_CMD, 8'h5A, 8'h00);
    cyc("R6 idle1", 0, A_PROT, 8'h00, 8'h00);
    cyc("R6 idle2", 0, A_OTH, 8'h00, 8'h00);
    chk("R6 still held", {7'b0, irq_hold}, 8'h01);
    cyc("R4 other", 1, A_OTH, 8'h77, 8'hFF);
    chk("R4 err", {7'b0, err_flag}, 8'h01);
    chk("R6 released", {7'b0, irq_hold}, 8'h00);
    cyc("R4 consumed", 1, A_PROT, 8'h77, 8'hFF);
    chk("R4 prot kept", prot_q, 8'hA5);
    cyc("R4 clr", 1, A_STS, 8'h00, 8'h01);
    // R8 set beats clear
    cyc("R8 cmd", 1, A_CMD, 8'hFF, 8'h00);
    cyc("R8 clear collide", 1, A_STS, 8'h00, 8'hFF);
    chk("R8 err wins", {7'b0, err_flag}, 8'h01);
    cyc("R8 clr", 1, A_STS, 8'h00, 8'h01);
    // R9 command while armed: error and fresh unlock
    cyc("R9 cmd1", 1, A_CMD, 8'h01, 8'h00);
    cyc("R9 cmd2", 1, A_CMD, 8'h02, 8'h00);
    chk("R9 err", {7'b0, err_flag}, 8'h01);
    cyc("R9 prot", 1, A_PROT, 8'hC3, 8'h00);
    chk("R9 accepted", prot_q, 8'hC3);
    cyc("R9 clr", 1, A_STS, 8'h00, 8'h01);

    // R2 exhaustive data sweep, dummy data varies
    for (int v = 0; v < 256; v++) begin
      cyc("R2 sweep cmd", 1, A_CMD, 8'(~v), 8'(v));
      cyc("R2 sweep prot", 1, A_PROT, 8'(v), 8'(~v));
      rd("R2 sweep read", A_PROT, 8'(v));
    end

    // mixed pseudo-random sequence against the reference
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: a = A_CMD;
        2'd1: a = A_PROT;
        2'd2: a = A_STS;
        default: a = A_OTH;
      endcase
      cyc("R8 mixed", lfsr[2] | lfsr[3], a, lfsr[15:8], {7'b0, lfsr[4]});
      rd("R7 mixed status", A_STS, {7'b0, m_err});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule